// File: doc/BRIEF.md
# Hashed Page Table Walker

This block turns a 32-bit logical address into a 32-bit physical address by searching a hashed page table that sits in memory. The four most significant logical address bits pick one of sixteen segment registers. Each register holds a 24-bit virtual segment identifier (VSID). That identifier, the 16-bit page index and the 12-bit byte offset together form a 52-bit virtual address. A hash of the VSID and the page index selects a 64-byte bucket of eight 8-byte page table entries. The walker reads the bucket one entry per cycle through a read port with a one-cycle latency.

The primary bucket is searched first. The overflow bucket, found through the complemented hash, is searched only when the primary bucket has no match. A hit returns the stored physical page number joined to the untouched byte offset. When both buckets fail, a miss flag is raised; it takes the place of a page-fault interrupt. Requests arrive on a valid/ready handshake. Each result is marked by a single-cycle done pulse and stays on the outputs until the next request is accepted.

Top module: `hpt_walker`

## Requirements
- R1: The VSID used for a walk is the content of segment register `req_laddr[31:28]` at the moment the request is accepted. Writing that register later in the same walk does not change the result.
- R2: Entry k of a bucket is read at `tbl_base | ((h & tbl_mask) << 6) | (k << 3)`. Here h is the 19-bit hash: the low 19 VSID bits XOR the zero-extended page index `req_laddr[27:12]`.
- R3: A table entry (bit 63 valid, bits 62:39 VSID, bit 38 hash-select, bits 37:32 page-index bits 15:10, bits 31:12 page number, bits 11:0 ignored) matches only when valid is 1, both VSID and index bits equal the request's, and hash-select is 0 in the primary bucket or 1 in the overflow bucket.
- R4: Within a bucket, entries are read in ascending order, one read per cycle. When more than one entry matches, the lowest-numbered one decides the result.
- R5: The overflow bucket uses hash ~h. Its first read comes only after all eight primary entries have been checked without a match.
- R6: When neither bucket matches, `miss` is 1, `hit` is 0 and `paddr` is 0. `hit` and `miss` are never both 1.
- R7: On a hit, `paddr` is the matching entry's page number in bits 31:12 and the request's byte offset in bits 11:0.
- R8: `req_ready` is 1 only while no walk is in progress. A request presented during a walk is ignored, and no memory read is issued while idle.
- R9: `done` is high for exactly one cycle per walk. `hit`, `miss` and `paddr` then hold until the next request is accepted.
- R10: Counted in clock edges after the accepting edge, `done` is visible k+2 edges later for a primary hit at entry k and k+11 edges later for an overflow hit at entry k. A miss takes 18 edges.
- R11: After reset, `req_ready` is 1 and `done`, `hit`, `miss`, `mem_rd_en` and `paddr` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sr_we | input | 1 | Segment register write strobe |
| sr_idx | input | 4 | Segment register being written |
| sr_wdata | input | 24 | VSID to store |
| tbl_base | input | 32 | Table base address, aligned to the table size |
| tbl_mask | input | 19 | Mask applied to the hash before it is shifted |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Walker idle and accepting |
| req_laddr | input | 32 | Logical address to translate |
| mem_rd_en | output | 1 | Table read strobe |
| mem_addr | output | 32 | Byte address of the entry being read |
| mem_rdata | input | 64 | Entry data, valid one cycle after the strobe |
| done | output | 1 | One-cycle completion pulse |
| hit | output | 1 | Translation found |
| miss | output | 1 | No translation; fault indication |
| paddr | output | 32 | Physical address when `hit` is 1, else 0 |

## Verification
The assertions assume a few things about the environment. Read data comes back exactly one cycle after each strobe. `tbl_base` is aligned to the table size, so the OR in the address does not lose carries. The base and the mask do not change during a walk. The bench's memory model is registered, answering every strobe on the next edge. The bench sets the base to a 4 KB-aligned address and changes the mask only between walks. The only inputs it touches mid-walk are `req_valid` and a segment register write, and both are there to show they have no effect.

// File: rtl/hpt_pkg.sv
package hpt_pkg;

   typedef enum logic [0:0] {
      WALK_IDLE = 1'b0,
      WALK_SCAN = 1'b1
   } walk_state_e;

   typedef enum logic [0:0] {
      PASS_PRIMARY  = 1'b0,
      PASS_OVERFLOW = 1'b1
   } walk_pass_e;

endpackage

// File: rtl/hpt_segregs.sv
module hpt_segregs #(
   parameter int SEG_BITS = 4,
   parameter int VSID_W   = 24
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                wr_en,
   input  logic [SEG_BITS-1:0] wr_idx,
   input  logic [VSID_W-1:0]   wr_vsid,
   input  logic [SEG_BITS-1:0] rd_idx,
   output logic [VSID_W-1:0]   rd_vsid
);
   localparam int NUM = 1 << SEG_BITS;

   logic [VSID_W-1:0] regs [NUM];

   for (genvar g = 0; g < NUM; g++) begin : g_seg
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            regs[g] <= '0;
         else if (wr_en && wr_idx == SEG_BITS'(g))
            regs[g] <= wr_vsid;
      end
   end

   assign rd_vsid = regs[rd_idx];
endmodule

// File: rtl/hpt_hash.sv
module hpt_hash #(
   parameter int VSID_W = 24,
   parameter int PIDX_W = 16,
   parameter int HASH_W = 19,
   parameter int AW     = 32,
   parameter int IDX_W  = 3,
   parameter int ENT_SH = 3
) (
   input  logic [VSID_W-1:0] vsid,
   input  logic [PIDX_W-1:0] pidx,
   input  logic              overflow,
   input  logic [AW-1:0]     base,
   input  logic [HASH_W-1:0] mask,
   input  logic [IDX_W-1:0]  slot,
   output logic [AW-1:0]     addr
);
   localparam int BKT_SH = IDX_W + ENT_SH;

   logic [HASH_W-1:0] h_pri;
   logic [HASH_W-1:0] h_sel;
   logic [HASH_W-1:0] h_msk;

   always_comb begin
      h_pri = vsid[HASH_W-1:0] ^ HASH_W'(pidx);
      h_sel = overflow ? ~h_pri : h_pri;
      h_msk = h_sel & mask;
      addr  = base | (AW'(h_msk) << BKT_SH) | (AW'(slot) << ENT_SH);
   end
endmodule

// File: rtl/hpt_match.sv
module hpt_match #(
   parameter int PTE_W  = 64,
   parameter int VSID_W = 24,
   parameter int API_W  = 6,
   parameter int PPN_W  = 20
) (
   input  logic [PTE_W-1:0]  pte,
   input  logic [VSID_W-1:0] vsid,
   input  logic [API_W-1:0]  api,
   input  logic              overflow,
   output logic              match,
   output logic [PPN_W-1:0]  ppn
);
   localparam int V_BIT    = PTE_W - 1;
   localparam int VSID_LSB = V_BIT - VSID_W;
   localparam int H_BIT    = VSID_LSB - 1;
   localparam int API_LSB  = H_BIT - API_W;
   localparam int PPN_LSB  = API_LSB - PPN_W;

   logic hk_unused;

   if (PPN_LSB > 0) begin : g_hk
      assign hk_unused = ^pte[PPN_LSB-1:0];
   end else begin : g_no_hk
      assign hk_unused = 1'b0;
   end

   assign match = pte[V_BIT]
                & (pte[V_BIT-1:VSID_LSB] == vsid)
                & (pte[H_BIT] == overflow)
                & (pte[H_BIT-1:API_LSB] == api);
   assign ppn   = pte[API_LSB-1:PPN_LSB];
endmodule

// File: rtl/hpt_walker.sv
module hpt_walker
   import hpt_pkg::*;
#(
   parameter int LA_W        = 32,
   parameter int OFF_W       = 12,
   parameter int SEG_BITS    = 4,
   parameter int VSID_W      = 24,
   parameter int API_W       = 6,
   parameter int PPN_W       = 20,
   parameter int HASH_W      = 19,
   parameter int PTE_W       = 64,
   parameter int BKT_ENTRIES = 8,
   parameter int MEM_AW      = 32
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 sr_we,
   input  logic [SEG_BITS-1:0]  sr_idx,
   input  logic [VSID_W-1:0]    sr_wdata,
   input  logic [MEM_AW-1:0]    tbl_base,
   input  logic [HASH_W-1:0]    tbl_mask,
   input  logic                 req_valid,
   output logic                 req_ready,
   input  logic [LA_W-1:0]      req_laddr,
   output logic                 mem_rd_en,
   output logic [MEM_AW-1:0]    mem_addr,
   input  logic [PTE_W-1:0]     mem_rdata,
   output logic                 done,
   output logic                 hit,
   output logic                 miss,
   output logic [PPN_W+OFF_W-1:0] paddr
);
   localparam int PIDX_W = LA_W - SEG_BITS - OFF_W;
   localparam int IDX_W  = $clog2(BKT_ENTRIES);
   localparam int CNT_W  = IDX_W + 1;
   localparam int ENT_SH = $clog2(PTE_W / 8);
   localparam int PA_W   = PPN_W + OFF_W;
   localparam logic [IDX_W-1:0] LAST_SLOT = IDX_W'(BKT_ENTRIES - 1);

   initial begin : elab_checks
      assert (HASH_W >= PIDX_W && HASH_W <= VSID_W)
         else $error("hash width must lie between page index and VSID widths");
      assert (API_W <= PIDX_W)
         else $error("abbreviated index wider than page index");
      assert ((1 << IDX_W) == BKT_ENTRIES)
         else $error("bucket entry count must be a power of two");
      assert (PTE_W >= 1 + VSID_W + 1 + API_W + PPN_W)
         else $error("entry too narrow for its fields");
   end

   walk_state_e          state_q;
   walk_pass_e           pass_q;
   logic [VSID_W-1:0]    vsid_q;
   logic [PIDX_W-1:0]    pidx_q;
   logic [OFF_W-1:0]     off_q;
   logic [CNT_W-1:0]     iss_cnt_q;
   logic                 chk_vld_q;
   logic [IDX_W-1:0]     chk_idx_q;
   logic                 done_q;
   logic                 hit_q;
   logic                 miss_q;
   logic [PPN_W-1:0]     ppn_q;

   logic [VSID_W-1:0]    seg_vsid;
   logic                 ent_match;
   logic [PPN_W-1:0]     ent_ppn;
   logic                 accept;
   logic                 overflow;

   hpt_segregs #(
      .SEG_BITS (SEG_BITS),
      .VSID_W   (VSID_W)
   ) u_segregs (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en   (sr_we),
      .wr_idx  (sr_idx),
      .wr_vsid (sr_wdata),
      .rd_idx  (req_laddr[LA_W-1 -: SEG_BITS]),
      .rd_vsid (seg_vsid)
   );

   assign overflow = (pass_q == PASS_OVERFLOW);

   hpt_hash #(
      .VSID_W (VSID_W),
      .PIDX_W (PIDX_W),
      .HASH_W (HASH_W),
      .AW     (MEM_AW),
      .IDX_W  (IDX_W),
      .ENT_SH (ENT_SH)
   ) u_hash (
      .vsid     (vsid_q),
      .pidx     (pidx_q),
      .overflow (overflow),
      .base     (tbl_base),
      .mask     (tbl_mask),
      .slot     (iss_cnt_q[IDX_W-1:0]),
      .addr     (mem_addr)
   );

   hpt_match #(
      .PTE_W  (PTE_W),
      .VSID_W (VSID_W),
      .API_W  (API_W),
      .PPN_W  (PPN_W)
   ) u_match (
      .pte      (mem_rdata),
      .vsid     (vsid_q),
      .api      (pidx_q[PIDX_W-1 -: API_W]),
      .overflow (overflow),
      .match    (ent_match),
      .ppn      (ent_ppn)
   );

   assign req_ready = (state_q == WALK_IDLE);
   assign accept    = req_ready & req_valid;
   assign mem_rd_en = (state_q == WALK_SCAN) && (iss_cnt_q < CNT_W'(BKT_ENTRIES));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q   <= WALK_IDLE;
         pass_q    <= PASS_PRIMARY;
         vsid_q    <= '0;
         pidx_q    <= '0;
         off_q     <= '0;
         iss_cnt_q <= '0;
         chk_vld_q <= 1'b0;
         chk_idx_q <= '0;
         done_q    <= 1'b0;
         hit_q     <= 1'b0;
         miss_q    <= 1'b0;
         ppn_q     <= '0;
      end else begin
         done_q <= 1'b0;
         unique case (state_q)
            WALK_IDLE: begin
               if (accept) begin
                  state_q   <= WALK_SCAN;
                  pass_q    <= PASS_PRIMARY;
                  vsid_q    <= seg_vsid;
                  pidx_q    <= req_laddr[OFF_W +: PIDX_W];
                  off_q     <= req_laddr[OFF_W-1:0];
                  iss_cnt_q <= '0;
                  chk_vld_q <= 1'b0;
                  hit_q     <= 1'b0;
                  miss_q    <= 1'b0;
               end
            end
            WALK_SCAN: begin
               if (mem_rd_en)
                  iss_cnt_q <= iss_cnt_q + 1'b1;
               chk_vld_q <= mem_rd_en;
               chk_idx_q <= iss_cnt_q[IDX_W-1:0];
               if (chk_vld_q) begin
                  if (ent_match) begin
                     state_q <= WALK_IDLE;
                     done_q  <= 1'b1;
                     hit_q   <= 1'b1;
                     ppn_q   <= ent_ppn;
                  end else if (chk_idx_q == LAST_SLOT) begin
                     if (pass_q == PASS_PRIMARY) begin
                        pass_q    <= PASS_OVERFLOW;
                        iss_cnt_q <= '0;
                        chk_vld_q <= 1'b0;
                     end else begin
                        state_q <= WALK_IDLE;
                        done_q  <= 1'b1;
                        miss_q  <= 1'b1;
                     end
                  end
               end
            end
            default: state_q <= WALK_IDLE;
         endcase
      end
   end

   assign done  = done_q;
   assign hit   = hit_q;
   assign miss  = miss_q;
   assign paddr = hit_q ? {ppn_q, off_q} : PA_W'(0);
endmodule

// File: rtl/hpt_walker_chk.sv
module hpt_walker_chk #(
   parameter int OFF_W  = 12,
   parameter int PA_W   = 32,
   parameter int ENT_SH = 3
) (
   input logic              clk,
   input logic              rst_n,
   input logic              req_valid,
   input logic              req_ready,
   input logic [OFF_W-1:0]  req_off,
   input logic              mem_rd_en,
   input logic [ENT_SH-1:0] addr_lo,
   input logic              done,
   input logic              hit,
   input logic              miss,
   input logic [PA_W-1:0]   paddr
);
   logic [OFF_W-1:0] off_seen;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         off_seen <= '0;
      else if (req_valid && req_ready)
         off_seen <= req_off;
   end

   p_no_read_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
      mem_rd_en |-> !req_ready);

   p_done_ready_r8: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> req_ready);

   p_done_single_r9: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);

   p_result_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (req_ready && !req_valid) |=> ($stable(hit) && $stable(miss) && $stable(paddr)));

   p_excl_r6: assert property (@(posedge clk) disable iff (!rst_n)
      !(hit && miss));

   p_miss_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (done && miss) |-> (paddr == '0));

   p_offset_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (done && hit) |-> (paddr[OFF_W-1:0] == off_seen));

   p_entry_align_r2: assert property (@(posedge clk) disable iff (!rst_n)
      mem_rd_en |-> (addr_lo == '0));

   p_result_flag_r9: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> $countones({hit, miss}) == 1);
endmodule

bind hpt_walker hpt_walker_chk #(
   .OFF_W  (OFF_W),
   .PA_W   (PPN_W + OFF_W),
   .ENT_SH ($clog2(PTE_W / 8))
) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .req_valid (req_valid),
   .req_ready (req_ready),
   .req_off   (req_laddr[OFF_W-1:0]),
   .mem_rd_en (mem_rd_en),
   .addr_lo   (mem_addr[$clog2(PTE_W / 8)-1:0]),
   .done      (done),
   .hit       (hit),
   .miss      (miss),
   .paddr     (paddr)
);

// File: tb/test_hpt_walker.sv
`timescale 1ns/1ps
module test_hpt_walker;
   localparam logic [31:0] BASE = 32'h0040_0000;
   localparam logic [18:0] MASK = 19'h0003F;

   // {laddr, expect hit, ppn, done latency in edges}
   localparam logic [60:0] VEC [6] = '{
      {32'h1012_3456, 1'b1, 20'hABCDE, 8'd2 },   // R2 R3 R7 R10 primary slot 0
      {32'h2204_0ABC, 1'b1, 20'h12345, 8'd7 },   // R4 R10 primary slot 5
      {32'h3444_4FFF, 1'b1, 20'h33333, 8'd14},   // R3 R5 decoys, overflow slot 3
      {32'h4800_1000, 1'b0, 20'h00000, 8'd18},   // R6 miss
      {32'h50F0_F00F, 1'b1, 20'h22222, 8'd4 },   // R4 first of two matches
      {32'h6FFF_F123, 1'b1, 20'h77777, 8'd18}    // R5 overflow slot 7
   };

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        sr_we = 1'b0;
   logic [3:0]  sr_idx = '0;
   logic [23:0] sr_wdata = '0;
   logic [31:0] tbl_base = BASE;
   logic [18:0] tbl_mask = MASK;
   logic        req_valid = 1'b0;
   logic        req_ready;
   logic [31:0] req_laddr = '0;
   logic        mem_rd_en;
   logic [31:0] mem_addr;
   logic [63:0] mem_rdata = '0;
   logic        done, hit, miss;
   logic [31:0] paddr;

   int checks = 0;
   int errors = 0;
   logic [63:0] mem [512];
   logic [31:0] rd_addr [32];
   int nrd;
   int lat;

   always #2.5 clk = ~clk;

   hpt_walker i_hpt_walker (
      .clk(clk), .rst_n(rst_n), .sr_we(sr_we), .sr_idx(sr_idx), .sr_wdata(sr_wdata),
      .tbl_base(tbl_base), .tbl_mask(tbl_mask), .req_valid(req_valid), .req_ready(req_ready),
      .req_laddr(req_laddr), .mem_rd_en(mem_rd_en), .mem_addr(mem_addr), .mem_rdata(mem_rdata),
      .done(done), .hit(hit), .miss(miss), .paddr(paddr)
   );

   always @(posedge clk) if (mem_rd_en) mem_rdata <= mem[mem_addr[11:3]];

   function automatic logic [23:0] vs(int s);
      return 24'hA50000 | 24'(s << 8);
   endfunction

   function automatic logic [31:0] eaddr(logic [23:0] v, logic [15:0] p, bit sec, int k, logic [18:0] m);
      logic [18:0] h;
      h = v[18:0] ^ {3'b000, p};
      if (sec) h = ~h;
      return BASE | ({13'b0, h & m} << 6) | 32'(k * 8);
   endfunction

   function automatic logic [63:0] pte(bit vld, logic [23:0] v, bit hs, logic [5:0] api, logic [19:0] ppn);
      return {vld, v, hs, api, ppn, 12'hAB5};
   endfunction

   task automatic put(logic [23:0] v, logic [15:0] p, bit sec, int k, logic [63:0] e);
      logic [31:0] a;
      a = eaddr(v, p, sec, k, MASK);
      mem[a[11:3]] = e;
   endtask

   task automatic check(bit ok, string req, string what, logic [63:0] act, logic [63:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
      end
   endtask

   task automatic write_sr(int s, logic [23:0] v);
      @(negedge clk);
      sr_we = 1'b1; sr_idx = 4'(s); sr_wdata = v;
      @(negedge clk);
      sr_we = 1'b0;
   endtask

   task automatic run(logic [31:0] la, logic [18:0] m, bit poke);
      @(negedge clk);
      tbl_mask = m;
      req_valid = 1'b1; req_laddr = la;
      @(posedge clk);
      @(negedge clk);
      req_valid = 1'b0;
      lat = 0; nrd = 0;
      while (!done && lat < 40) begin
         if (mem_rd_en) begin
            if (nrd < 32) rd_addr[nrd] = mem_addr;
            nrd++;
         end
         if (poke && lat == 3) begin
            check(req_ready == 1'b0, "R8", "ready during walk", 64'(req_ready), 64'd0);
            req_valid = 1'b1; req_laddr = 32'h1012_3456;
            sr_we = 1'b1; sr_idx = la[31:28]; sr_wdata = 24'h0;
         end
         if (poke && lat == 4) begin
            req_valid = 1'b0; sr_we = 1'b0;
         end
         @(posedge clk); lat++;
         @(negedge clk);
      end
   endtask

   task automatic verify(string tag, logic [31:0] la, logic [18:0] m, logic [23:0] v,
                         bit eh, logic [19:0] eppn, int elat);
      logic [31:0] epa;
      int enrd;
      bit addr_ok;
      logic [31:0] bad_a, bad_e;
      epa = eh ? {eppn, la[11:0]} : 32'h0;
      check(hit == eh, tag, "hit R3", 64'(hit), 64'(eh));
      check(miss == !eh, tag, "miss R6", 64'(miss), 64'(!eh));
      check(paddr == epa, tag, "paddr R7", 64'(paddr), 64'(epa));
      check(lat == elat, tag, "latency R10", 64'(lat), 64'(elat));
      enrd = (elat <= 9) ? ((elat < 8) ? elat : 8) : 8 + (((elat - 9) < 8) ? (elat - 9) : 8);
      check(nrd == enrd, tag, "read count R4 R5", 64'(nrd), 64'(enrd));
      addr_ok = 1'b1; bad_a = '0; bad_e = '0;
      for (int j = 0; j < nrd && j < 32; j++) begin
         logic [31:0] ea;
         ea = (j < 8) ? eaddr(v, la[27:12], 1'b0, j, m) : eaddr(v, la[27:12], 1'b1, j - 8, m);
         if (rd_addr[j] !== ea && addr_ok) begin
            addr_ok = 1'b0; bad_a = rd_addr[j]; bad_e = ea;
         end
      end
      check(addr_ok, tag, "read address order R2 R4 R5", 64'(bad_a), 64'(bad_e));
   endtask

   initial begin : watchdog
      repeat (20000) @(posedge clk);
      errors++;
      checks++;
      $display("FAIL R10 watchdog: actual hang expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin : main
      for (int i = 0; i < 512; i++) mem[i] = '0;
      put(vs(1), 16'h0123, 0, 0, pte(1, vs(1), 0, 6'h00, 20'hABCDE));
      put(vs(2), 16'h2040, 0, 5, pte(1, vs(2), 0, 6'h08, 20'h12345));
      put(vs(3), 16'h4444, 0, 0, pte(1, vs(3), 1, 6'h11, 20'h0BAD0));
      put(vs(3), 16'h4444, 0, 1, pte(0, vs(3), 0, 6'h11, 20'h0BAD1));
      put(vs(3), 16'h4444, 0, 2, pte(1, vs(3), 0, 6'h12, 20'h0BAD2));
      put(vs(3), 16'h4444, 0, 3, pte(1, vs(2), 0, 6'h11, 20'h0BAD3));
      put(vs(3), 16'h4444, 1, 1, pte(1, vs(3), 0, 6'h11, 20'h0BAD4));
      put(vs(3), 16'h4444, 1, 3, pte(1, vs(3), 1, 6'h11, 20'h33333));
      put(vs(5), 16'h0F0F, 0, 2, pte(1, vs(5), 0, 6'h03, 20'h22222));
      put(vs(5), 16'h0F0F, 0, 6, pte(1, vs(5), 0, 6'h03, 20'h66666));
      put(vs(6), 16'hFFFF, 1, 7, pte(1, vs(6), 1, 6'h3F, 20'h77777));

      repeat (3) @(negedge clk);
      // R11 reset state
      check(req_ready == 1'b1, "R11", "ready", 64'(req_ready), 64'd1);
      check(done == 1'b0, "R11", "done", 64'(done), 64'd0);
      check(hit == 1'b0, "R11", "hit", 64'(hit), 64'd0);
      check(miss == 1'b0, "R11", "miss", 64'(miss), 64'd0);
      check(mem_rd_en == 1'b0, "R11", "rd_en", 64'(mem_rd_en), 64'd0);
      check(paddr == 32'h0, "R11", "paddr", 64'(paddr), 64'd0);
      rst_n = 1'b1;

      for (int s = 0; s < 16; s++) write_sr(s, vs(s));

      for (int i = 0; i < 6; i++) begin
         logic [31:0] la;
         la = VEC[i][60:29];
         run(la, MASK, 1'b0);
         verify($sformatf("vec%0d", i), la, MASK, vs(int'(la[31:28])), VEC[i][28], VEC[i][27:8], int'(VEC[i][7:0]));
      end

      // R9: single pulse and held result after a hit
      run(32'h1012_3456, MASK, 1'b0);
      @(negedge clk);
      check(done == 1'b0, "R9", "done width", 64'(done), 64'd0);
      repeat (3) @(negedge clk);
      check(hit == 1'b1, "R9", "hit held", 64'(hit), 64'd1);
      check(paddr == 32'hABCD_E456, "R9", "paddr held", 64'(paddr), 64'hABCDE456);

      // R8 R1: request and segment write during a walk are ignored
      run(32'h4800_1000, MASK, 1'b1);
      verify("R8_R1_busy", 32'h4800_1000, MASK, vs(4), 1'b0, 20'h0, 18);
      write_sr(4, vs(4));
      @(negedge clk);
      check(req_ready == 1'b1, "R8", "ready after walk", 64'(req_ready), 64'd1);
      check(mem_rd_en == 1'b0, "R8", "no read while idle", 64'(mem_rd_en), 64'd0);

      // R1: segment register content chooses the VSID
      write_sr(1, vs(6));
      run(32'h1FFF_F123, MASK, 1'b0);
      verify("R1_segsel", 32'h1FFF_F123, MASK, vs(6), 1'b1, 20'h77777, 18);
      write_sr(1, vs(1));

      // R2 R6: zero mask folds both buckets onto the base
      run(32'h1012_3456, 19'h0, 1'b0);
      verify("R2_mask0", 32'h1012_3456, 19'h0, vs(1), 1'b0, 20'h0, 18);
      check(rd_addr[0] == BASE, "R2", "first read at base", 64'(rd_addr[0]), 64'(BASE));
      check(rd_addr[8] == BASE, "R5", "overflow read at base", 64'(rd_addr[8]), 64'(BASE));
      tbl_mask = MASK;

      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule